// File: doc/BRIEF.md
# Data Access Region Protection Checker

This block sits beside the load/store path of a processor core and decides, for every data access, whether it may go ahead. Four regions can be programmed. Each region has a base address, a size code and enable, read and write permission bits. Each access arrives with an address, a read/write flag and a valid strobe. In the same cycle the block reports whether an enabled region matched, which region supplied the attributes, and whether the access is allowed or faults.

Region sizes are powers of two from 4 KB up to 16 MB. A region matches on the address bits at and above its size, so a region always sits on a boundary of its own size. Regions may overlap. The lowest-numbered matching region wins. An address that matches no region takes a global default permission pair. Software loads the configuration through a small synchronous register port, and each write takes effect at the next clock edge.

Top module: `memprot_unit`

## Requirements
- R1: There are four regions. Writing `cfg_sel` = 0..3 loads region n from `cfg_wdata`: base in bits [31:12], enable in bit 6, write permission in bit 5, read permission in bit 4 and size code in bits [3:0].
- R2: Size code k (0..12) gives a region of 4 KB << k. An address matches when its bits at and above position 12+k equal the same bits of the base.
- R3: Base bits below the selected size are ignored, so a misaligned base behaves as if it were aligned down to the region size.
- R4: A size code of 13, 14 or 15 disables the region, whatever its enable bit.
- R5: When several enabled regions match, the lowest-numbered one supplies the permissions and is reported on `hit_idx`.
- R6: When no enabled region matches, `hit` is 0, `hit_idx` is 0 and the permissions come from the default register. Writing `cfg_sel` = 4 sets the default register, with read permission in bit 4 and write permission in bit 5.
- R7: With `acc_valid` high, a write (`acc_write`=1) without write permission, or a read (`acc_write`=0) without read permission, raises `fault` and keeps `allow` low in the same cycle. Otherwise `allow` is high and `fault` is low.
- R8: While `acc_valid` is low, `hit`, `hit_idx`, `allow` and `fault` are all 0.
- R9: A configuration write changes the checking only after the next rising clock edge. Synchronous reset disables all regions and clears both default permissions.
- R10: Writes with `cfg_sel` = 5..7 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| acc_valid | input | 1 | Access strobe |
| acc_addr | input | 32 | Access address |
| acc_write | input | 1 | 1 = store, 0 = load |
| hit | output | 1 | An enabled region matched |
| hit_idx | output | 2 | Region that supplied the permissions |
| allow | output | 1 | Access permitted |
| fault | output | 1 | Access violates the permissions |

## Verification
Directed cases cover several things:
- addresses one byte inside and one byte outside a region edge, which tells a correct size mask from one that is off by one bit;
- a misaligned base, which shows whether the low base bits are masked;
- nested regions with different permissions, which shows which region wins priority;
- illegal size codes;
- probes placed just before and just after a configuration edge, which show when a write takes effect.

Random configurations with addresses drawn near the region bases mix hits, misses and overlaps. A bench model predicts every output, so errors in the read/write permission choice and in the default path are told apart from errors in matching.

// File: rtl/memprot_pkg.sv
package memprot_pkg;
    localparam int ADDR_W      = 32;
    localparam int DATA_W      = 32;
    localparam int NUM_REGIONS = 4;
    localparam int IDX_W       = $clog2(NUM_REGIONS);
    localparam int SEL_W       = 3;
    localparam int MIN_SHIFT   = 12;
    localparam int NUM_SIZES   = 13;
    localparam int CODE_W      = 4;

    localparam int BIT_RD = 4;
    localparam int BIT_WR = 5;
    localparam int BIT_EN = 6;

    typedef struct packed {
        logic                          en;
        logic                          rd;
        logic                          wr;
        logic [CODE_W-1:0]             code;
        logic [ADDR_W-1:MIN_SHIFT]     base;
    } region_cfg_t;

    typedef struct packed {
        logic rd;
        logic wr;
    } perm_t;

    function automatic logic size_legal(input logic [CODE_W-1:0] code);
        return int'(code) < NUM_SIZES;
    endfunction

    function automatic logic [ADDR_W-1:0] size_mask(input logic [CODE_W-1:0] code);
        return {ADDR_W{1'b1}} << (MIN_SHIFT + int'(code));
    endfunction
endpackage

// File: rtl/memprot_regfile.sv
module memprot_regfile
    import memprot_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_we,
    input  logic [SEL_W-1:0]        cfg_sel,
    input  logic [DATA_W-1:0]       cfg_wdata,
    output region_cfg_t             regions [NUM_REGIONS],
    output perm_t                   dflt
);
    for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regions[i] <= '0;
            end else if (cfg_we && int'(cfg_sel) == i) begin
                regions[i].en   <= cfg_wdata[BIT_EN];
                regions[i].rd   <= cfg_wdata[BIT_RD];
                regions[i].wr   <= cfg_wdata[BIT_WR];
                regions[i].code <= cfg_wdata[CODE_W-1:0];
                regions[i].base <= cfg_wdata[ADDR_W-1:MIN_SHIFT];
            end
        end

        assert_cfg_load_R1: assert property (@(posedge clk) disable iff (rst)
            (cfg_we && int'(cfg_sel) == i) |=>
                (regions[i].code == $past(cfg_wdata[CODE_W-1:0]) &&
                 regions[i].en == $past(cfg_wdata[BIT_EN])));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dflt <= '0;
        end else if (cfg_we && int'(cfg_sel) == NUM_REGIONS) begin
            dflt.rd <= cfg_wdata[BIT_RD];
            dflt.wr <= cfg_wdata[BIT_WR];
        end
    end

    assert_unused_sel_R10: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && int'(cfg_sel) > NUM_REGIONS) |=> $stable(dflt));
endmodule

// File: rtl/memprot_match.sv
module memprot_match
    import memprot_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  region_cfg_t       cfg,
    input  logic [ADDR_W-1:0] addr,
    output logic              match
);
    logic [ADDR_W-1:0] mask;
    logic [ADDR_W-1:0] base_full;

    always_comb begin
        mask      = size_mask(cfg.code);
        base_full = {cfg.base, {MIN_SHIFT{1'b0}}};
        match     = cfg.en && size_legal(cfg.code) && (((addr ^ base_full) & mask) == '0);
    end

    assert_bad_code_R4: assert property (@(posedge clk) disable iff (rst)
        (int'(cfg.code) >= NUM_SIZES) |-> !match);
    assert_disabled_R1: assert property (@(posedge clk) disable iff (rst)
        !cfg.en |-> !match);
endmodule

// File: rtl/memprot_resolve.sv
module memprot_resolve
    import memprot_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   valid,
    input  logic                   is_write,
    input  logic [NUM_REGIONS-1:0] match,
    input  perm_t                  perms [NUM_REGIONS],
    input  perm_t                  dflt,
    output logic                   hit,
    output logic [IDX_W-1:0]       hit_idx,
    output logic                   allow,
    output logic                   fault
);
    perm_t            sel_perm;
    logic [IDX_W-1:0] win;
    logic             ok;

    always_comb begin
        sel_perm = dflt;
        win      = '0;
        for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
            if (match[i]) begin
                sel_perm = perms[i];
                win      = IDX_W'(i);
            end
        end
        ok      = is_write ? sel_perm.wr : sel_perm.rd;
        hit     = valid && (|match);
        hit_idx = valid ? win : '0;
        allow   = valid && ok;
        fault   = valid && !ok;
    end

    assert_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !valid |-> (!hit && !allow && !fault && hit_idx == '0));
    assert_excl_R7: assert property (@(posedge clk) disable iff (rst)
        valid |-> (allow != fault));
    assert_winner_R5: assert property (@(posedge clk) disable iff (rst)
        hit |-> match[hit_idx]);
    assert_default_R6: assert property (@(posedge clk) disable iff (rst)
        (valid && match == '0) |-> (allow == (is_write ? dflt.wr : dflt.rd)));
endmodule

// File: rtl/memprot_unit.sv
module memprot_unit
    import memprot_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [31:0]       cfg_wdata,
    input  logic              acc_valid,
    input  logic [31:0]       acc_addr,
    input  logic              acc_write,
    output logic              hit,
    output logic [1:0]        hit_idx,
    output logic              allow,
    output logic              fault
);
    region_cfg_t            regions [NUM_REGIONS];
    perm_t                  dflt;
    perm_t                  perms   [NUM_REGIONS];
    logic [NUM_REGIONS-1:0] match;

    memprot_regfile u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .regions   (regions),
        .dflt      (dflt)
    );

    for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_match
        memprot_match u_match (
            .clk   (clk),
            .rst   (rst),
            .cfg   (regions[i]),
            .addr  (acc_addr),
            .match (match[i])
        );
        assign perms[i].rd = regions[i].rd;
        assign perms[i].wr = regions[i].wr;
    end

    memprot_resolve u_resolve (
        .clk      (clk),
        .rst      (rst),
        .valid    (acc_valid),
        .is_write (acc_write),
        .match    (match),
        .perms    (perms),
        .dflt     (dflt),
        .hit      (hit),
        .hit_idx  (hit_idx),
        .allow    (allow),
        .fault    (fault)
    );
endmodule

// File: tb/memprot_unit_tb.sv
module memprot_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        acc_write = 1'b0;
    logic        hit, allow, fault;
    logic [1:0]  hit_idx;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [19:0] m_base [4];
    logic [3:0]  m_code [4];
    logic        m_en [4], m_rd [4], m_wr [4];
    logic        d_rd, d_wr;

    always #2.5 clk = ~clk;

    memprot_unit u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_write(acc_write),
        .hit(hit), .hit_idx(hit_idx), .allow(allow), .fault(fault)
    );

    function automatic logic [31:0] mk(logic [31:0] base, logic en, logic wr, logic rd, logic [3:0] code);
        return {base[31:12], 5'd0, en, wr, rd, code};
    endfunction

    function automatic logic [4:0] model(logic v, logic [31:0] a, logic w);
        logic h; logic [1:0] idx; logic p;
        h = 1'b0; idx = 2'd0; p = w ? d_wr : d_rd;
        for (int i = 3; i >= 0; i--) begin
            if (m_en[i] && m_code[i] < 4'd13 &&
                ((a >> (12 + m_code[i])) == ({m_base[i], 12'd0} >> (12 + m_code[i])))) begin
                h = 1'b1; idx = 2'(i); p = w ? m_wr[i] : m_rd[i];
            end
        end
        if (!v) return 5'd0;
        return {h, idx, p, !p};
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 4; i++) begin
            m_base[i] = '0; m_code[i] = '0; m_en[i] = 0; m_rd[i] = 0; m_wr[i] = 0;
        end
        d_rd = 0; d_wr = 0;
    endtask

    task automatic model_write(logic [2:0] s, logic [31:0] d);
        if (s < 3'd4) begin
            m_base[s[1:0]] = d[31:12]; m_code[s[1:0]] = d[3:0];
            m_en[s[1:0]] = d[6]; m_wr[s[1:0]] = d[5]; m_rd[s[1:0]] = d[4];
        end else if (s == 3'd4) begin
            d_rd = d[4]; d_wr = d[5];
        end
    endtask

    task automatic cfg(logic [2:0] s, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(posedge clk);
        model_write(s, d);
        #1 cfg_we = 1'b0;
    endtask

    task automatic compare(string req, logic [4:0] exp);
        logic [4:0] act;
        act = {hit, hit_idx, allow, fault};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s addr=%h wr=%0b actual hit/idx/allow/fault=%b expected=%b",
                     req, acc_addr, acc_write, act, exp);
        end
    endtask

    task automatic probe(string req, logic v, logic [31:0] a, logic w);
        @(negedge clk);
        acc_valid = v; acc_addr = a; acc_write = w;
        #1 compare(req, model(v, a, w));
    endtask

    initial begin
        #400000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R8 idle and R9 reset state
        probe("R8", 1'b0, 32'h0000_1000, 1'b0);
        probe("R9", 1'b1, 32'h0000_0000, 1'b0);
        compare("R9", 5'b00001);

        // R1/R2: 64KB region 0 at 0x10000, read only
        cfg(3'd0, mk(32'h0001_0000, 1, 0, 1, 4'd4));
        probe("R2", 1'b1, 32'h0001_FFFF, 1'b0);
        compare("R2", 5'b10010);
        probe("R2", 1'b1, 32'h0002_0000, 1'b0);
        probe("R2", 1'b1, 32'h0000_FFFF, 1'b0);
        probe("R7", 1'b1, 32'h0001_0010, 1'b1);
        compare("R7", 5'b10001);

        // R3: misaligned base aligns down
        cfg(3'd1, mk(32'h0003_5000, 1, 1, 1, 4'd4));
        probe("R3", 1'b1, 32'h0003_0004, 1'b1);
        compare("R3", 5'b10110);

        // R5: 16MB write-only region 2 covers region 0
        cfg(3'd2, mk(32'h0000_0000, 1, 1, 0, 4'd12));
        probe("R5", 1'b1, 32'h0001_0020, 1'b0);
        compare("R5", 5'b10010);
        probe("R5", 1'b1, 32'h0001_0020, 1'b1);
        compare("R5", 5'b10001);
        probe("R5", 1'b1, 32'h0050_0000, 1'b1);
        compare("R5", 5'b11010);

        // R4: illegal size codes
        cfg(3'd3, mk(32'h0100_0000, 1, 1, 1, 4'd13));
        probe("R4", 1'b1, 32'h0100_0000, 1'b0);
        compare("R4", 5'b00001);
        cfg(3'd3, mk(32'h0100_0000, 1, 1, 1, 4'd15));
        probe("R4", 1'b1, 32'h0100_0040, 1'b1);
        cfg(3'd3, mk(32'h0100_0000, 1, 1, 1, 4'd12));
        probe("R4", 1'b1, 32'h01FF_FFFF, 1'b1);
        compare("R4", 5'b11110);

        // R6: default permissions
        cfg(3'd4, 32'h0000_0010);
        probe("R6", 1'b1, 32'h0400_0000, 1'b0);
        compare("R6", 5'b00010);
        probe("R6", 1'b1, 32'h0400_0000, 1'b1);

        // R10: unused selects
        cfg(3'd5, 32'hFFFF_FFFF);
        cfg(3'd7, 32'hFFFF_FFFF);
        probe("R10", 1'b1, 32'h0400_0000, 1'b1);
        compare("R10", 5'b00001);
        probe("R10", 1'b1, 32'h0001_0000, 1'b1);

        // R9: write takes effect only after the edge
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 3'd4; cfg_wdata = 32'h0000_0020;
        acc_valid = 1'b1; acc_addr = 32'h0800_0000; acc_write = 1'b1;
        #1 compare("R9", 5'b00001);
        @(posedge clk);
        model_write(3'd4, 32'h0000_0020);
        #1 cfg_we = 1'b0;
        compare("R9", 5'b00010);

        // R8 with active config
        for (int k = 0; k < 20; k++) probe("R8", 1'b0, $urandom, 1'($urandom));

        // Random mix of R1..R7
        for (int k = 0; k < 600; k++) begin
            if (k % 25 == 0) begin
                for (int r = 0; r < 5; r++) begin
                    logic [31:0] b;
                    b = {8'd0, 24'($urandom)} & 32'h00FF_F000;
                    cfg(3'(r), mk(b, 1'($urandom % 5 != 0), 1'($urandom), 1'($urandom),
                                  4'($urandom % 16)));
                end
            end
            begin
                logic [31:0] a;
                int r;
                r = $urandom % 4;
                a = {m_base[r], 12'd0} ^ (32'($urandom) >> ($urandom % 32));
                probe("R1-random R5 R7", 1'($urandom % 8 != 0), a, 1'($urandom));
            end
        end

        // reset again: R9
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        model_reset();
        #1 rst = 1'b0;
        probe("R9", 1'b1, 32'h0001_0000, 1'b0);
        compare("R9", 5'b00001);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule